// File: doc/BRIEF.md
# Byte/Word ALU with Condition Flags

A purely combinational arithmetic and logic unit for a 16-bit microcontroller datapath. Each cycle it takes a 4-bit operation code, a source operand, a destination operand, a byte/word selector and the carry held by the status register. It returns the result, a flag that says whether the result should be written back, and new values for the N, Z, C and V flags. Each flag also has its own update enable, so the status register keeps any flag whose enable is low.

Two-operand operations combine the source with the destination. One-operand operations (rotate, arithmetic shift, byte swap, sign extend) take their operand from the destination input and ignore the source. Subtraction reuses the adder: the source is inverted and a carry-in of 1 (or of the incoming carry) is added. Decimal add works one BCD digit at a time, passing the carry from each digit to the next.

Top module: `bcd_flag_alu`

## Requirements
- R1: Operation codes are MOV=0, ADD=1, ADDC=2, SUB=3, SUBC=4, CMP=5, DADD=6, BIT=7, BIC=8, BIS=9, XOR=10, AND=11, RRC=12, RRA=13, SWPB=14, SXT=15. MOV passes the source through, BIC gives dst & ~src, and BIS gives dst | src. MOV, BIC, BIS and SWPB leave all four flag enables low. A flag output is 0 whenever its enable is low.
- R2: ADD gives dst+src. ADDC gives dst+src+carry_i. SUB and CMP give dst+~src+1. SUBC gives dst+~src+carry_i. ADD, SUB and CMP ignore carry_i. Z is set for a zero result, N is the sign bit and C is the carry out.
- R3: When byte_i=1, bits 15..8 of both operands are ignored, the sign bit is bit 7 and the carry comes out of bit 8. Result bits 15..8 are 0 for every operation except SWPB and SXT. When byte_i=0, the sign bit is bit 15 and the carry comes out of bit 16.
- R4: For ADD, ADDC, SUB, SUBC and CMP, V is set when the two adder inputs (the source after any inversion, and the destination) have equal signs and the sign of the result differs from them.
- R5: CMP and BIT hold wb_o at 0 but still drive res_o and update all four flags. Every other operation sets wb_o to 1.
- R6: DADD adds BCD digit by digit, starting with carry_i. C is the decimal carry out of the top digit (digit 1 in byte mode, digit 3 in word mode). Z is set for a zero result, N is the sign bit and V is 0.
- R7: AND and BIT compute dst & src, and XOR computes dst ^ src. For AND, BIT, XOR and SXT, C is set when the masked result is nonzero, Z is set when it is zero, and N is the sign bit.
- R8: XOR sets V when both operands are negative. AND, BIT and SXT clear V.
- R9: RRC shifts the operand right by one and puts carry_i into the sign bit. RRA shifts right by one and keeps the sign bit. Both put the old bit 0 into C, set Z and N from the result, and clear V.
- R10: SWPB swaps the two bytes of the 16-bit operand whatever byte_i is. SXT copies bit 7 into bits 15..8 and sets N when bit 7 is 1.
- R11: Every operation other than MOV, BIC, BIS and SWPB raises all four flag enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (encoding in R1) |
| byte_i | input | 1 | 1 = byte operation, 0 = word operation |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand; the operand of one-operand operations |
| carry_i | input | 1 | Current C flag |
| res_o | output | 16 | Result |
| wb_o | output | 1 | Result should be written to the destination |
| n_o | output | 1 | New N flag |
| z_o | output | 1 | New Z flag |
| c_o | output | 1 | New C flag |
| v_o | output | 1 | New V flag |
| n_we_o | output | 1 | Update enable for N |
| z_we_o | output | 1 | Update enable for Z |
| c_we_o | output | 1 | Update enable for C |
| v_we_o | output | 1 | Update enable for V |

## Verification
The hardest cases to reach are those where one operation's carry or overflow crosses a width boundary.

Carries in decimal add have to ripple through every digit. Vectors such as 0x7999 plus 0x0001 push a carry from digit 0 to the top digit and flip the sign bit. A byte-mode decimal add with carry-in lands on exactly zero with a carry out.

Byte-mode vectors put nonzero data in the upper operand bytes. This shows that those bits cannot leak into the result or into the flags.

Signed overflow in subtraction shows up only after the source is inverted, so the operands are chosen so that the inverted source and the destination share a sign.

// File: rtl/bcd_flag_alu.sv
module bcd_flag_alu #(
  parameter int W = 16
) (
  input  logic [3:0]   op_i,
  input  logic         byte_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic         carry_i,
  output logic [W-1:0] res_o,
  output logic         wb_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o,
  output logic         n_we_o,
  output logic         z_we_o,
  output logic         c_we_o,
  output logic         v_we_o
);
  localparam int HW = W / 2;
  localparam int DIGITS = W / 4;
  localparam int BYTE_DIGITS = HW / 4;

  localparam logic [3:0] OP_MOV  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_ADDC = 4'd2;
  localparam logic [3:0] OP_SUB  = 4'd3;
  localparam logic [3:0] OP_SUBC = 4'd4;
  localparam logic [3:0] OP_CMP  = 4'd5;
  localparam logic [3:0] OP_DADD = 4'd6;
  localparam logic [3:0] OP_BIT  = 4'd7;
  localparam logic [3:0] OP_BIC  = 4'd8;
  localparam logic [3:0] OP_BIS  = 4'd9;
  localparam logic [3:0] OP_XOR  = 4'd10;
  localparam logic [3:0] OP_AND  = 4'd11;
  localparam logic [3:0] OP_RRC  = 4'd12;
  localparam logic [3:0] OP_RRA  = 4'd13;
  localparam logic [3:0] OP_SWPB = 4'd14;
  localparam logic [3:0] OP_SXT  = 4'd15;

  logic [W-1:0] mask, a, b, bb, r, dres;
  logic [W:0]   sum;
  logic         inv, cin, sa, sb, sr, dc, dc_byte, keep_flags;
  logic [4:0]   dig;

  assign mask = byte_i ? {{HW{1'b0}}, {HW{1'b1}}} : {W{1'b1}};
  assign a    = dst_i & mask;
  assign b    = src_i & mask;
  assign inv  = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
  assign bb   = inv ? (~b & mask) : b;
  assign cin  = ((op_i == OP_ADDC) || (op_i == OP_SUBC)) ? carry_i
              : ((op_i == OP_SUB) || (op_i == OP_CMP));
  assign sum  = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, cin};
  assign sa   = byte_i ? a[HW-1]  : a[W-1];
  assign sb   = byte_i ? bb[HW-1] : bb[W-1];

  always_comb begin
    dc = carry_i;
    dc_byte = 1'b0;
    dres = '0;
    for (int i = 0; i < DIGITS; i++) begin
      dig = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'd0, dc};
      if (dig > 5'd9) begin
        dig = dig + 5'd6;
        dc = 1'b1;
      end else begin
        dc = 1'b0;
      end
      dres[4*i +: 4] = dig[3:0];
      if (i == BYTE_DIGITS - 1) dc_byte = dc;
    end
  end

  always_comb begin
    r = '0;
    wb_o = 1'b1;
    c_o = 1'b0;
    v_o = 1'b0;
    keep_flags = 1'b0;
    unique case (op_i)
      OP_MOV: begin r = b; keep_flags = 1'b1; end
      OP_BIC: begin r = a & ~b; keep_flags = 1'b1; end
      OP_BIS: begin r = a | b; keep_flags = 1'b1; end
      OP_SWPB: begin r = {dst_i[HW-1:0], dst_i[W-1:HW]}; keep_flags = 1'b1; end
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        r = sum[W-1:0] & mask;
        c_o = byte_i ? sum[HW] : sum[W];
        v_o = (sa == sb) && ((byte_i ? r[HW-1] : r[W-1]) != sa);
        wb_o = (op_i != OP_CMP);
      end
      OP_DADD: begin
        r = dres & mask;
        c_o = byte_i ? dc_byte : dc;
      end
      OP_AND, OP_BIT, OP_XOR: begin
        r = (op_i == OP_XOR) ? (a ^ b) : (a & b);
        c_o = |r;
        v_o = (op_i == OP_XOR) && sa && (byte_i ? b[HW-1] : b[W-1]);
        wb_o = (op_i != OP_BIT);
      end
      OP_RRC, OP_RRA: begin
        r = a >> 1;
        if (byte_i) r[HW-1] = (op_i == OP_RRC) ? carry_i : a[HW-1];
        else        r[W-1]  = (op_i == OP_RRC) ? carry_i : a[W-1];
        c_o = a[0];
      end
      OP_SXT: begin
        r = {{HW{dst_i[HW-1]}}, dst_i[HW-1:0]};
        c_o = |r;
      end
      default: r = '0;
    endcase
    sr = byte_i ? r[HW-1] : r[W-1];
    if (op_i == OP_SXT) sr = dst_i[HW-1];
    res_o = r;
    n_o = keep_flags ? 1'b0 : sr;
    z_o = keep_flags ? 1'b0 : (r == '0);
    if (keep_flags) begin
      c_o = 1'b0;
      v_o = 1'b0;
    end
    n_we_o = !keep_flags;
    z_we_o = !keep_flags;
    c_we_o = !keep_flags;
    v_we_o = !keep_flags;

    assert_no_write_R5: assert (!((op_i == OP_CMP || op_i == OP_BIT) && wb_o));
    assert_flags_held_R1: assert (!((op_i == OP_MOV || op_i == OP_BIC || op_i == OP_BIS
                                     || op_i == OP_SWPB) && (n_we_o || z_we_o || c_we_o || v_we_o)));
    assert_upper_clear_R3: assert (!(byte_i && op_i != OP_SWPB && op_i != OP_SXT
                                     && res_o[W-1:HW] != '0));
    assert_logic_cz_R7: assert (!((op_i == OP_AND || op_i == OP_BIT || op_i == OP_XOR
                                   || op_i == OP_SXT) && (c_o == z_o)));
    assert_sxt_ext_R10: assert (!(op_i == OP_SXT && res_o[W-1:HW] != {HW{res_o[HW-1]}}));
  end
endmodule

// File: tb/bcd_flag_alu_bench.sv
module bcd_flag_alu_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  op;
  logic        byt, cin;
  logic [15:0] src, dst, res;
  logic        wb, n, z, c, v, nwe, zwe, cwe, vwe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bcd_flag_alu u_bcd_flag_alu (
    .op_i(op), .byte_i(byt), .src_i(src), .dst_i(dst), .carry_i(cin),
    .res_o(res), .wb_o(wb), .n_o(n), .z_o(z), .c_o(c), .v_o(v),
    .n_we_o(nwe), .z_we_o(zwe), .c_we_o(cwe), .v_we_o(vwe)
  );

  // {op, byte, cin, src, dst, res, wb, enables nzcv, flags nzcv}
  localparam logic [62:0] VEC [0:26] = '{
    {4'd1, 1'b0,1'b0,16'h0001,16'h7FFF,16'h8000,1'b1,4'hF,4'b1001},
    {4'd1, 1'b1,1'b0,16'h00FF,16'h1201,16'h0000,1'b1,4'hF,4'b0110},
    {4'd2, 1'b0,1'b1,16'h0001,16'hFFFF,16'h0001,1'b1,4'hF,4'b0010},
    {4'd3, 1'b0,1'b0,16'h0001,16'h0001,16'h0000,1'b1,4'hF,4'b0110},
    {4'd3, 1'b0,1'b0,16'h0001,16'h8000,16'h7FFF,1'b1,4'hF,4'b0011},
    {4'd4, 1'b1,1'b0,16'h0001,16'h0001,16'h00FF,1'b1,4'hF,4'b1000},
    {4'd5, 1'b0,1'b0,16'h0005,16'h0003,16'hFFFE,1'b0,4'hF,4'b1000},
    {4'd6, 1'b0,1'b0,16'h0199,16'h0001,16'h0200,1'b1,4'hF,4'b0000},
    {4'd6, 1'b1,1'b1,16'h0050,16'h0049,16'h0000,1'b1,4'hF,4'b0110},
    {4'd6, 1'b0,1'b0,16'h9999,16'h0001,16'h0000,1'b1,4'hF,4'b0110},
    {4'd6, 1'b0,1'b0,16'h7999,16'h0001,16'h8000,1'b1,4'hF,4'b1000},
    {4'd7, 1'b0,1'b0,16'h00F0,16'h0F0F,16'h0000,1'b0,4'hF,4'b0100},
    {4'd11,1'b1,1'b0,16'hFF80,16'h12C3,16'h0080,1'b1,4'hF,4'b1010},
    {4'd10,1'b0,1'b0,16'h8001,16'h8003,16'h0002,1'b1,4'hF,4'b0011},
    {4'd10,1'b1,1'b0,16'h00AA,16'h00AA,16'h0000,1'b1,4'hF,4'b0101},
    {4'd8, 1'b0,1'b1,16'h00FF,16'hABCD,16'hAB00,1'b1,4'h0,4'b0000},
    {4'd9, 1'b1,1'b0,16'h0F00,16'h1230,16'h0030,1'b1,4'h0,4'b0000},
    {4'd0, 1'b1,1'b0,16'h1234,16'hFFFF,16'h0034,1'b1,4'h0,4'b0000},
    {4'd0, 1'b0,1'b1,16'hBEEF,16'h0000,16'hBEEF,1'b1,4'h0,4'b0000},
    {4'd12,1'b0,1'b1,16'h0000,16'h0002,16'h8001,1'b1,4'hF,4'b1000},
    {4'd12,1'b1,1'b0,16'h0000,16'h0001,16'h0000,1'b1,4'hF,4'b0110},
    {4'd13,1'b0,1'b0,16'h0000,16'h8003,16'hC001,1'b1,4'hF,4'b1010},
    {4'd13,1'b1,1'b0,16'h0000,16'hFF81,16'h00C0,1'b1,4'hF,4'b1010},
    {4'd14,1'b1,1'b0,16'h0000,16'h12AB,16'hAB12,1'b1,4'h0,4'b0000},
    {4'd15,1'b0,1'b0,16'h0000,16'h0080,16'hFF80,1'b1,4'hF,4'b1010},
    {4'd15,1'b0,1'b0,16'h0000,16'hFF00,16'h0000,1'b1,4'hF,4'b0100},
    {4'd15,1'b0,1'b0,16'h0000,16'h007F,16'h007F,1'b1,4'hF,4'b0010}
  };

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd8, 4'd9: return "R1";
      4'd1, 4'd2, 4'd3, 4'd4: return "R2/R4";
      4'd5, 4'd7: return "R5";
      4'd6: return "R6";
      4'd10: return "R8";
      4'd11: return "R7";
      4'd12, 4'd13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic bm, input logic ci,
                       input logic [15:0] s, input logic [15:0] d);
    @(negedge clk);
    op = o; byt = bm; cin = ci; src = s; dst = d;
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] er, input logic ew,
                       input logic [3:0] een, input logic [3:0] efl);
    checks++;
    if (res !== er || wb !== ew || {nwe,zwe,cwe,vwe} !== een || {n,z,c,v} !== efl) begin
      errors++;
      $display("FAIL %s: got res=%h wb=%b en=%b nzcv=%b, expected res=%h wb=%b en=%b nzcv=%b",
               req, res, wb, {nwe,zwe,cwe,vwe}, {n,z,c,v}, er, ew, een, efl);
    end
  endtask

  initial begin
    op = '0; byt = 0; cin = 0; src = '0; dst = '0;
    for (int i = 0; i < 27; i++) begin
      apply(VEC[i][62:59], VEC[i][58], VEC[i][57], VEC[i][56:41], VEC[i][40:25]);
      check(tag_of(VEC[i][62:59]), VEC[i][24:9], VEC[i][8], VEC[i][7:4], VEC[i][3:0]);
    end
    // R2: ADD ignores carry_i
    apply(4'd1, 1'b0, 1'b1, 16'h0001, 16'h0002);
    check("R2", 16'h0003, 1'b1, 4'hF, 4'b0000);
    // R3: upper operand bytes ignored in byte subtract, borrow visible in bit 8 carry
    apply(4'd3, 1'b1, 1'b0, 16'hAB02, 16'hCD01);
    check("R3", 16'h00FF, 1'b1, 4'hF, 4'b1000);
    // R11: SUBC with carry set behaves as plain subtract
    apply(4'd4, 1'b0, 1'b1, 16'h0003, 16'h0005);
    check("R11", 16'h0002, 1'b1, 4'hF, 4'b0010);
    // R10: SWPB ignores byte mode and never touches flags
    apply(4'd14, 1'b0, 1'b1, 16'hFFFF, 16'h00FF);
    check("R10", 16'hFF00, 1'b1, 4'h0, 4'b0000);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule